// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Counter

This block keeps time of day and the calendar in packed BCD: seconds, minutes, hours (24-hour only), day of week, date, month, year and century. A single-cycle tick, pulsed once per second, advances it. Date rollover follows the length of each month, and February gets its 29th day in leap years. A year counts as a leap year when its two-digit value is divisible by 4, so year 00 is a leap year. A carry out of year 99 moves the century on.

Two copies of the time exist. The internal copy counts on every tick. The user copy is the one the byte port reads and writes. While the transfer-enable input is high, the user copy follows the internal one, one cycle after each increment. Software drops transfer-enable to read a frozen, consistent snapshot, or to set the time. Only the fields written during the freeze are marked for loading. On the rising edge of transfer-enable those fields go into the internal counters, and every other field keeps the count it reached in the meantime. The month byte also carries three control bits (oscillator stop, active-low square-wave enable, backup square-wave enable). The block only stores them for software, and they never take part in counting.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the eight fields read, at addresses 0 to 7: seconds 00h, minutes 00h, hours 00h, day 01h, date 01h, month 01h (control bits 0), year 00h, century 20h.
- R2: Seconds and minutes count 00 to 59 in BCD and hours count 00 to 23. Each wraps to 00 and carries into the next field, so 23:59:59 plus one tick gives 00:00:00 and a new day.
- R3: At midnight the day-of-week code increments, and it wraps from 07h to 01h.
- R4: The date wraps to 01 and carries into the month after 30 in months 04h, 06h, 09h and 11h, and after 31 in the other months. In 02h it wraps after 29 when the two-digit year is divisible by 4 (00 included) and after 28 otherwise.
- R5: The month wraps from 12h to 01h and increments the year. The year wraps from 99h to 00h and increments the century, which wraps from 39h to 00h.
- R6: With transfer-enable at 1, the user copy takes the new time on the second rising clock edge after the edge that samples the tick. It still shows the old value between those two edges.
- R7: With transfer-enable at 0, the user copy does not change on ticks, but the internal count goes on. Raising transfer-enable with no fields written shows the advanced time two edges later.
- R8: A write to address 0 to 7 while transfer-enable is 0 updates the user field at once and marks it. On the rising edge of transfer-enable only the marked fields are loaded into the internal count, and the marks clear.
- R9: Writes to the time value bits while transfer-enable is 1 have no effect.
- R10: Address map: 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year, 7 century. Writable value bits are 6:0 for seconds and minutes, 5:0 for hours and date, 2:0 for day, 4:0 for month, 7:0 for year and 5:0 for century. The other bits read 0. Bits 7:5 of the month byte are control bits. A write stores them whatever the state of transfer-enable, and counting and copying leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| xfer_en_i | input | 1 | Transfer enable: 1 = user copy follows the count, 0 = frozen |
| addr_i | input | 3 | Register address 0 to 7 |
| wr_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed user field (combinational) |

## Verification
Each rollover case starts from a time loaded one cycle before 23:59:59 or at 23:59:59, followed by one tick. This covers a non-leap February, leap Februaries with a year of 24 and of 00, a 30-day month, a 31st day that must not wrap, the year-end carry into the century, and the century wrap. Comparing these cases separates the month-length and leap decisions from the plain BCD carry chain. The tests of the transfer path freeze the user copy across several ticks and then release it, with and without a written field. These show whether the internal count kept running, and whether only the written field was loaded. The remaining tests cover writes with transfer-enable at 1, writes that set unused bits, and control-bit writes. They show that the value bits ignore such writes, that the unused bits read 0, and that the control bits are kept apart from the counting.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int NF = 8;
  localparam int BW = 8;
  localparam int AW = $clog2(NF);
  localparam int CW = 3;

  typedef logic [BW-1:0] bcd_t;
  typedef logic [NF-1:0][BW-1:0] cal_set_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;
  localparam int F_CEN  = 7;

  function automatic bcd_t field_mask(int idx);
    case (idx)
      F_SEC, F_MIN:  return 8'h7F;
      F_HR, F_DATE:  return 8'h3F;
      F_DOW:         return 8'h07;
      F_MON:         return 8'h1F;
      F_YR:          return 8'hFF;
      default:       return 8'h3F;
    endcase
  endfunction

  function automatic bcd_t rst_value(int idx, bcd_t cen);
    case (idx)
      F_DOW, F_DATE, F_MON: return 8'h01;
      F_CEN:                return cen;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic bcd_t bcd_next(bcd_t v, bcd_t last, bcd_t first);
    if (v == last) return first;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(bcd_t yr);
    logic [6:0] bin;
    bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return bin[1:0] == 2'b00;
  endfunction

  function automatic bcd_t month_last_date(bcd_t mon, bcd_t yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_step.sv
`timescale 1ns/1ps
module cal_step
  import cal_pkg::*;
(
  input  cal_set_t cur_i,
  input  logic     adv_i,
  output cal_set_t nxt_o,
  output logic     midnight_o,
  output logic     year_roll_o
);
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    c_min = (cur_i[F_SEC] == 8'h59);
    c_hr  = c_min && (cur_i[F_MIN] == 8'h59);
    c_day = c_hr  && (cur_i[F_HR] == 8'h23);
    c_mon = c_day && (cur_i[F_DATE] == month_last_date(cur_i[F_MON], cur_i[F_YR]));
    c_yr  = c_mon && (cur_i[F_MON] == 8'h12);
    c_cen = c_yr  && (cur_i[F_YR] == 8'h99);
  end

  always_comb begin
    nxt_o = cur_i;
    if (adv_i) begin
      nxt_o[F_SEC] = bcd_next(cur_i[F_SEC], 8'h59, 8'h00);
      if (c_min) nxt_o[F_MIN] = bcd_next(cur_i[F_MIN], 8'h59, 8'h00);
      if (c_hr)  nxt_o[F_HR]  = bcd_next(cur_i[F_HR], 8'h23, 8'h00);
      if (c_day) begin
        nxt_o[F_DOW]  = bcd_next(cur_i[F_DOW], 8'h07, 8'h01);
        nxt_o[F_DATE] = bcd_next(cur_i[F_DATE],
                                 month_last_date(cur_i[F_MON], cur_i[F_YR]), 8'h01);
      end
      if (c_mon) nxt_o[F_MON] = bcd_next(cur_i[F_MON], 8'h12, 8'h01);
      if (c_yr)  nxt_o[F_YR]  = bcd_next(cur_i[F_YR], 8'h99, 8'h00);
      if (c_cen) nxt_o[F_CEN] = bcd_next(cur_i[F_CEN], 8'h39, 8'h00);
    end
  end

  assign midnight_o  = adv_i && c_day;
  assign year_roll_o = adv_i && c_yr;
endmodule

// File: rtl/cal_core.sv
`timescale 1ns/1ps
module cal_core
  import cal_pkg::*;
#(
  parameter bcd_t RST_CEN = 8'h20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [NF-1:0] dirty_i,
  input  cal_set_t      user_i,
  output cal_set_t      int_o,
  output logic          midnight_o,
  output logic          year_roll_o
);
  cal_set_t merged, nxt;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    bcd_t fld_q;
    assign merged[g] = (load_i && dirty_i[g]) ? (user_i[g] & field_mask(g)) : fld_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) fld_q <= rst_value(g, RST_CEN);
      else         fld_q <= nxt[g];
    end
    assign int_o[g] = fld_q;
  end

  cal_step u_step (
    .cur_i       (merged),
    .adv_i       (tick_i),
    .nxt_o       (nxt),
    .midnight_o  (midnight_o),
    .year_roll_o (year_roll_o)
  );
endmodule

// File: rtl/cal_user.sv
`timescale 1ns/1ps
module cal_user
  import cal_pkg::*;
#(
  parameter bcd_t RST_CEN = 8'h20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  bcd_t          wdata_i,
  input  logic          xfer_en_i,
  input  logic          copy_i,
  input  logic          load_i,
  input  cal_set_t      int_i,
  output cal_set_t      user_o,
  output logic [NF-1:0] dirty_o,
  output logic [CW-1:0] ctrl_o
);
  for (genvar g = 0; g < NF; g++) begin : g_fld
    bcd_t fld_q;
    logic dirty_q;
    logic hit;
    assign hit = wr_i && !xfer_en_i && (addr_i == AW'(g));
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        fld_q   <= rst_value(g, RST_CEN);
        dirty_q <= 1'b0;
      end else begin
        if (hit)         fld_q <= wdata_i & field_mask(g);
        else if (copy_i) fld_q <= int_i[g];
        if (hit)         dirty_q <= 1'b1;
        else if (load_i) dirty_q <= 1'b0;
      end
    end
    assign user_o[g]  = fld_q;
    assign dirty_o[g] = dirty_q;
  end

  logic [CW-1:0] ctrl_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_i && (addr_i == AW'(F_MON))) ctrl_q <= wdata_i[BW-1 -: CW];
  end
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
  import cal_pkg::*;
#(
  parameter bcd_t RST_CEN = 8'h20
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   xfer_en_i,
  input  logic [cal_pkg::AW-1:0] addr_i,
  input  logic                   wr_i,
  input  logic [cal_pkg::BW-1:0] wdata_i,
  output logic [cal_pkg::BW-1:0] rdata_o
);
  logic xfer_q, tick_q, load_q;
  logic load_pulse, copy_pulse, midnight, year_roll;
  logic [NF-1:0] dirty;
  logic [CW-1:0] ctrl;
  cal_set_t int_set, user_set;

  assign load_pulse = xfer_en_i && !xfer_q;
  assign copy_pulse = xfer_en_i && (tick_q || load_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      xfer_q <= 1'b1;
      tick_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      xfer_q <= xfer_en_i;
      tick_q <= tick_i;
      load_q <= load_pulse;
    end
  end

  cal_core #(.RST_CEN(RST_CEN)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .load_i      (load_pulse),
    .dirty_i     (dirty),
    .user_i      (user_set),
    .int_o       (int_set),
    .midnight_o  (midnight),
    .year_roll_o (year_roll)
  );

  cal_user #(.RST_CEN(RST_CEN)) u_user (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .xfer_en_i (xfer_en_i),
    .copy_i    (copy_pulse),
    .load_i    (load_pulse),
    .int_i     (int_set),
    .user_o    (user_set),
    .dirty_o   (dirty),
    .ctrl_o    (ctrl)
  );

  assign rdata_o = user_set[addr_i] |
                   ((addr_i == AW'(F_MON)) ? {ctrl, {(BW-CW){1'b0}}} : '0);
endmodule

// File: rtl/cal_checker.sv
`timescale 1ns/1ps
module cal_checker
  import cal_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          xfer_en_i,
  input logic          wr_i,
  input logic          load_pulse,
  input logic          copy_pulse,
  input logic          midnight,
  input logic          year_roll,
  input cal_set_t      int_set,
  input cal_set_t      user_set,
  input logic [NF-1:0] dirty
);
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_pulse && int_set[F_SEC] == 8'h59) |=> int_set[F_SEC] == 8'h00); // R2

  AST_DOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (midnight && !load_pulse && int_set[F_DOW] == 8'h07) |=> int_set[F_DOW] == 8'h01); // R3

  AST_YEAR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (year_roll && !load_pulse && int_set[F_YR] == 8'h99) |=>
      (int_set[F_YR] == 8'h00 && int_set[F_CEN] != $past(int_set[F_CEN]))); // R5

  AST_COPY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_pulse |=> user_set == $past(int_set)); // R6

  AST_USER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_en_i && !wr_i) |=> $stable(user_set)); // R7

  AST_INT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_pulse) |=> $stable(int_set)); // R7

  AST_DIRTY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse |=> dirty == '0); // R8

  AST_TE_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_en_i && !copy_pulse) |=> $stable(user_set)); // R9
endmodule

bind bcd_calendar cal_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .xfer_en_i  (xfer_en_i),
  .wr_i       (wr_i),
  .load_pulse (load_pulse),
  .copy_pulse (copy_pulse),
  .midnight   (midnight),
  .year_roll  (year_roll),
  .int_set    (int_set),
  .user_set   (user_set),
  .dirty      (dirty)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, xfer = 1'b1, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  always #10 clk = ~clk;

  bcd_calendar uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .xfer_en_i(xfer),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [2:0] a;
    logic [7:0] d;
    string      tag;
  } exp_t;
  exp_t sb[$];

  function automatic void check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops expected items and compares them at the read port
  initial forever begin
    wait (sb.size() > 0);
    @(negedge clk);
    addr = sb[0].a;
    #2;
    check($sformatf("%s addr %0d", sb[0].tag, sb[0].a), rdata, sb[0].d);
    sb.delete(0);
  end

  task automatic expect_rd(logic [2:0] a, logic [7:0] d, string tag);
    sb.push_back('{a: a, d: d, tag: tag});
    wait (sb.size() == 0);
  endtask

  task automatic expect_time(logic [7:0] s, mi, h, dw, dt, mo, y, c, string tag);
    expect_rd(3'd0, s, tag);  expect_rd(3'd1, mi, tag);
    expect_rd(3'd2, h, tag);  expect_rd(3'd3, dw, tag);
    expect_rd(3'd4, dt, tag); expect_rd(3'd5, mo, tag);
    expect_rd(3'd6, y, tag);  expect_rd(3'd7, c, tag);
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_xfer();
    @(negedge clk); xfer = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_time(logic [7:0] s, mi, h, dw, dt, mo, y, c);
    @(negedge clk); xfer = 1'b0;
    wr_reg(3'd0, s);  wr_reg(3'd1, mi); wr_reg(3'd2, h);  wr_reg(3'd3, dw);
    wr_reg(3'd4, dt); wr_reg(3'd5, mo); wr_reg(3'd6, y);  wr_reg(3'd7, c);
    release_xfer();
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20, "R1 reset");

    // non-leap February, R6 timing of the copy
    load_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, 8'h20);
    expect_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, 8'h20, "R8 R10 load all");
    @(negedge clk); addr = 3'd0; tick = 1'b1;
    @(negedge clk); tick = 1'b0; #2;
    check("R6 before copy", rdata, 8'h58);
    @(negedge clk); #2;
    check("R6 after copy", rdata, 8'h59);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23, 8'h20, "R2 R3 R4 feb28");

    // leap years
    load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, 8'h20, "R4 leap 24");
    load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h29, 8'h02, 8'h24, 8'h20);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h03, 8'h24, 8'h20, "R4 feb29 end");
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00, 8'h21);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h21, "R4 leap 00");

    // 30 and 31 day months
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25, 8'h20);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h25, 8'h20, "R4 april");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h25, 8'h20);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h05, 8'h25, 8'h20, "R4 may 31");

    // year and century carry
    load_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h20);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00, 8'h21, "R5 year end");
    load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h39);
    pulse_tick();
    expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, "R5 R3 century wrap");

    // freeze: internal keeps counting
    load_time(8'h10, 8'h30, 8'h12, 8'h04, 8'h15, 8'h06, 8'h25, 8'h20);
    @(negedge clk); xfer = 1'b0;
    pulse_tick(); pulse_tick(); pulse_tick();
    expect_rd(3'd0, 8'h10, "R7 frozen");
    release_xfer();
    expect_rd(3'd0, 8'h13, "R7 kept counting");

    // only written field is loaded
    @(negedge clk); xfer = 1'b0;
    wr_reg(3'd1, 8'h42);
    pulse_tick(); pulse_tick();
    expect_rd(3'd1, 8'h42, "R8 written visible");
    expect_rd(3'd0, 8'h13, "R8 R7 frozen sec");
    release_xfer();
    expect_time(8'h15, 8'h42, 8'h12, 8'h04, 8'h15, 8'h06, 8'h25, 8'h20, "R8 merge");

    // writes with transfer-enable high
    wr_reg(3'd0, 8'h33);
    expect_rd(3'd0, 8'h15, "R9 sec write ignored");
    wr_reg(3'd6, 8'h77);
    expect_rd(3'd6, 8'h25, "R9 year write ignored");
    wr_reg(3'd5, 8'hE9);
    expect_rd(3'd5, 8'hE6, "R10 R9 control bits only");
    pulse_tick();
    expect_rd(3'd0, 8'h16, "R10 tick after ctrl");
    expect_rd(3'd5, 8'hE6, "R10 ctrl retained");

    // unused bits and control bits while frozen
    @(negedge clk); xfer = 1'b0;
    wr_reg(3'd2, 8'hD7);
    expect_rd(3'd2, 8'h17, "R10 hour unused bits");
    wr_reg(3'd3, 8'hFD);
    expect_rd(3'd3, 8'h05, "R10 day unused bits");
    wr_reg(3'd5, 8'h47);
    expect_rd(3'd5, 8'h47, "R10 month write");
    release_xfer();
    expect_time(8'h16, 8'h42, 8'h17, 8'h05, 8'h15, 8'h47, 8'h25, 8'h20, "R10 R8 after load");
    pulse_tick();
    expect_rd(3'd0, 8'h17, "R2 count after load");
    expect_rd(3'd5, 8'h47, "R10 ctrl kept");

    finish_run();
  end
endmodule